// File: doc/BRIEF.md
# Next Program Counter and Link Unit

This block holds the program counter of a 32-bit load/store core. In each cycle it works out where fetch goes next. Its inputs are the current program counter, the fetched instruction word, the result of the equality compare of the two source registers, and the value of the first source register. From these it selects one of four addresses:

- the sequential address (program counter plus four);
- a PC-relative branch target;
- a pseudo-direct jump target;
- a register-indirect return address.

The selected address is driven out combinationally as `next_pc_o` and is loaded into the internal program counter at the next rising edge. For the call instruction, the unit also raises a write request for the link register and supplies the return address to be written.

The register file, the compare logic and the decoding of every other opcode sit outside the block. The core only feeds in the instruction and the two register-derived values and reads back the fetch address and the link write.

Reset is asynchronous and active low. Its release is synchronised internally over two clock edges. While the block is in reset, and until that synchronisation completes, the program counter holds the reset vector.

Top module: `nxpc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals the parameter `RESET_VEC`. After release, `pc_o` stays at `RESET_VEC` until the second rising edge after `rst_n` goes high, and it first advances at the third.
- R2: For any opcode (bits 31:26) other than 0, 2, 3, 4 and 5, and for opcode 0 with function field (bits 5:0) other than 8, `next_pc_o` equals `pc_o + 4`.
- R3: For opcode 4, `next_pc_o` is `pc_o + 4 + (imm << 2)` when `cmp_eq_i` is 1, and `pc_o + 4` when it is 0. Here `imm` is bits 15:0 of the instruction.
- R4: For opcode 5, `next_pc_o` is `pc_o + 4 + (imm << 2)` when `cmp_eq_i` is 0, and `pc_o + 4` when it is 1.
- R5: The 16-bit branch offset is sign-extended before it is shifted, so an offset with bit 15 set moves the program counter backwards (modulo 2^32).
- R6: For opcode 2, `next_pc_o` is `{pc_o[31:28], instr_i[25:0], 2'b00}`.
- R7: For opcode 3, `next_pc_o` is formed as in R6. In the same cycle `link_we_o` is 1 and `link_val_o` equals `pc_o + 4`.
- R8: For opcode 0 with function field 8, `next_pc_o` equals `rs_val_i`.
- R9: `link_we_o` is 0 for every instruction except opcode 3, and `link_dst_o` always equals the parameter `LINK_REG` (default 31).
- R10: Once the reset synchroniser has released, `pc_o` takes the value that `next_pc_o` had at each rising edge.
- R11: The upper four bits of a jump target come from the current `pc_o`, not from `pc_o + 4`, even when the increment carries into bit 28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word fetched at `pc_o` |
| cmp_eq_i | input | 1 | 1 when the two source registers compare equal |
| rs_val_i | input | 32 | Value of the first source register |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address that will be loaded at the next edge |
| link_we_o | output | 1 | Link register write request |
| link_dst_o | output | 5 | Link register number |
| link_val_o | output | 32 | Return address to write into the link register |

## Verification
The bench builds the unit with `RESET_VEC` set to decimal 80000 and leaves `LINK_REG` at 31. With that reset vector, a short loop placed at that address can be executed directly from reset. Its taken not-equal branch at 80012 must land on 80024, and its jump at 80020 with field 20000 must return to 80000. A register-indirect return to `0x1FFFFFFC` then sets up the jump case where the increment carries into bit 28, which is needed to check that the region bits come from the current program counter.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  localparam int XW     = 32;
  localparam int OPW    = 6;
  localparam int IMMW   = 16;
  localparam int IDXW   = 26;
  localparam int REGW   = 5;
  localparam int REGION = XW - IDXW - 2;

  localparam logic [OPW-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OPW-1:0] OP_JUMP    = 6'd2;
  localparam logic [OPW-1:0] OP_CALL    = 6'd3;
  localparam logic [OPW-1:0] OP_BR_EQ   = 6'd4;
  localparam logic [OPW-1:0] OP_BR_NE   = 6'd5;
  localparam logic [5:0]     FN_RETURN  = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BRANCH,
    FLOW_JUMP,
    FLOW_CALL,
    FLOW_INDIRECT
  } flow_e;

  typedef struct packed {
    flow_e            kind;
    logic             want_ne;
    logic [IMMW-1:0]  offset;
    logic [IDXW-1:0]  index;
  } flow_dec_t;

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
  import nxpc_pkg::*;
(
  input  logic [XW-1:0] instr,
  output flow_dec_t     dec
);

  logic [OPW-1:0] opcode;
  logic [5:0]     funct;

  assign opcode = instr[XW-1 -: OPW];
  assign funct  = instr[5:0];

  always_comb begin
    dec         = '0;
    dec.kind    = FLOW_SEQ;
    dec.offset  = instr[IMMW-1:0];
    dec.index   = instr[IDXW-1:0];
    dec.want_ne = 1'b0;
    unique case (opcode)
      OP_SPECIAL: if (funct == FN_RETURN) dec.kind = FLOW_INDIRECT;
      OP_JUMP:    dec.kind = FLOW_JUMP;
      OP_CALL:    dec.kind = FLOW_CALL;
      OP_BR_EQ:   dec.kind = FLOW_BRANCH;
      OP_BR_NE: begin
        dec.kind    = FLOW_BRANCH;
        dec.want_ne = 1'b1;
      end
      default:    dec.kind = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
  import nxpc_pkg::*;
(
  input  logic [XW-1:0] pc,
  input  flow_dec_t     dec,
  output logic [XW-1:0] seq_pc,
  output logic [XW-1:0] branch_pc,
  output logic [XW-1:0] jump_pc
);

  localparam int EXTW = XW - IMMW - 2;

  logic [XW-1:0] disp;

  assign seq_pc    = pc + XW'(4);
  assign disp      = {{EXTW{dec.offset[IMMW-1]}}, dec.offset, 2'b00};
  assign branch_pc = seq_pc + disp;
  assign jump_pc   = {pc[XW-1 -: REGION], dec.index, 2'b00};

endmodule

// File: rtl/nxpc_select.sv
module nxpc_select
  import nxpc_pkg::*;
(
  input  flow_dec_t     dec,
  input  logic          cmp_eq,
  input  logic [XW-1:0] rs_val,
  input  logic [XW-1:0] seq_pc,
  input  logic [XW-1:0] branch_pc,
  input  logic [XW-1:0] jump_pc,
  output logic [XW-1:0] next_pc,
  output logic          link_we
);

  logic taken;

  assign taken = (dec.kind == FLOW_BRANCH) && (cmp_eq ^ dec.want_ne);

  always_comb begin
    next_pc = seq_pc;
    link_we = 1'b0;
    case (dec.kind)
      FLOW_BRANCH:   if (taken) next_pc = branch_pc;
      FLOW_JUMP:     next_pc = jump_pc;
      FLOW_CALL: begin
        next_pc = jump_pc;
        link_we = 1'b1;
      end
      FLOW_INDIRECT: next_pc = rs_val;
      default:       next_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000,
  parameter logic [4:0]  LINK_REG  = 5'd31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr_i,
  input  logic        cmp_eq_i,
  input  logic [31:0] rs_val_i,
  output logic [31:0] pc_o,
  output logic [31:0] next_pc_o,
  output logic        link_we_o,
  output logic [4:0]  link_dst_o,
  output logic [31:0] link_val_o
);

  logic          rel_meta_q;
  logic          run_q;
  logic [XW-1:0] pc_q;
  logic [XW-1:0] pc_d;
  flow_dec_t     dec;
  logic [XW-1:0] seq_pc;
  logic [XW-1:0] branch_pc;
  logic [XW-1:0] jump_pc;
  logic [XW-1:0] next_pc;
  logic          link_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_meta_q <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      rel_meta_q <= 1'b1;
      run_q      <= rel_meta_q;
    end
  end

  nxpc_decode u_dec (
    .instr (instr_i),
    .dec   (dec)
  );

  nxpc_target u_tgt (
    .pc        (pc_q),
    .dec       (dec),
    .seq_pc    (seq_pc),
    .branch_pc (branch_pc),
    .jump_pc   (jump_pc)
  );

  nxpc_select u_sel (
    .dec       (dec),
    .cmp_eq    (cmp_eq_i),
    .rs_val    (rs_val_i),
    .seq_pc    (seq_pc),
    .branch_pc (branch_pc),
    .jump_pc   (jump_pc),
    .next_pc   (next_pc),
    .link_we   (link_we)
  );

  always_comb begin
    pc_d = pc_q;
    if (run_q) pc_d = next_pc;
    else       pc_d = RESET_VEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_VEC;
    else        pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign next_pc_o  = next_pc;
  assign link_we_o  = link_we;
  assign link_dst_o = LINK_REG;
  assign link_val_o = seq_pc;

endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000,
  parameter logic [4:0]  LINK_REG  = 5'd31
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run_q,
  input logic [31:0] instr_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] pc_o,
  input logic [31:0] next_pc_o,
  input logic        link_we_o,
  input logic [4:0]  link_dst_o,
  input logic [31:0] link_val_o
);

  logic [5:0] op;
  logic       plain_op;
  assign op       = instr_i[31:26];
  assign plain_op = (op != 6'd0) && (op != 6'd2) && (op != 6'd3) &&
                    (op != 6'd4) && (op != 6'd5);

  // R1
  hold_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (pc_o == RESET_VEC));

  // R10
  pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (pc_o == $past(next_pc_o)));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plain_op |-> (next_pc_o == pc_o + 32'd4));

  // R7
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (link_val_o == pc_o + 32'd4));

  // R9
  link_only_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o == (op == 6'd3));

  // R9
  link_dst_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_dst_o == LINK_REG);

  // R11
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 6'd2) || (op == 6'd3)) |->
      ((next_pc_o[31:28] == pc_o[31:28]) && (next_pc_o[1:0] == 2'b00)));

  // R8
  indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 6'd0) && (instr_i[5:0] == 6'd8)) |-> (next_pc_o == rs_val_i));

endmodule

bind nxpc_unit nxpc_unit_chk #(
  .RESET_VEC (RESET_VEC),
  .LINK_REG  (LINK_REG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_q      (run_q),
  .instr_i    (instr_i),
  .rs_val_i   (rs_val_i),
  .pc_o       (pc_o),
  .next_pc_o  (next_pc_o),
  .link_we_o  (link_we_o),
  .link_dst_o (link_dst_o),
  .link_val_o (link_val_o)
);

// File: tb/nxpc_unit_test.sv
module nxpc_unit_test;

  localparam logic [31:0] RV = 32'd80000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = 32'd0;
  logic        cmp_eq_i = 1'b0;
  logic [31:0] rs_val_i = 32'd0;
  logic [31:0] pc_o, next_pc_o, link_val_o;
  logic        link_we_o;
  logic [4:0]  link_dst_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_pc;

  logic [31:0] q_pc[$];
  logic [31:0] q_nxt[$];
  logic [31:0] q_val[$];
  logic        q_we[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  nxpc_unit #(.RESET_VEC(RV), .LINK_REG(5'd31)) uut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .cmp_eq_i(cmp_eq_i),
    .rs_val_i(rs_val_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
    .link_we_o(link_we_o), .link_dst_o(link_dst_o), .link_val_o(link_val_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d (0x%08h) expected=%0d (0x%08h)",
               tag, what, act, act, exp, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd8, 5'd21, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] a);
    return {op, a};
  endfunction

  function automatic logic [31:0] enc_ret();
    return {6'd0, 5'd31, 15'd0, 6'h08};
  endfunction

  // Reference from the requirements
  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                           input logic eq, input logic [31:0] rsv);
    logic [31:0] off;
    off = {{14{ins[15]}}, ins[15:0], 2'b00};
    case (ins[31:26])
      6'd0: return (ins[5:0] == 6'd8) ? rsv : pc + 32'd4;
      6'd2, 6'd3: return {pc[31:28], ins[25:0], 2'b00};
      6'd4: return eq ? pc + 32'd4 + off : pc + 32'd4;
      6'd5: return !eq ? pc + 32'd4 + off : pc + 32'd4;
      default: return pc + 32'd4;
    endcase
  endfunction

  task automatic step_x(input logic [31:0] ins, input logic eq, input logic [31:0] rsv,
                        input logic [31:0] exp_next, input string tag);
    @(negedge clk);
    instr_i  = ins;
    cmp_eq_i = eq;
    rs_val_i = rsv;
    q_pc.push_back(model_pc);
    q_nxt.push_back(exp_next);
    q_we.push_back(ins[31:26] == 6'd3);
    q_val.push_back(model_pc + 32'd4);
    q_tag.push_back(tag);
    model_pc = exp_next;
  endtask

  task automatic step(input logic [31:0] ins, input logic eq, input logic [31:0] rsv,
                      input string tag);
    step_x(ins, eq, rsv, ref_next(model_pc, ins, eq, rsv), tag);
  endtask

  // Monitor: pops expected items once the combinational outputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_nxt.size() > 0) begin
        logic [31:0] e_pc, e_nxt, e_val;
        logic e_we;
        string t;
        e_pc = q_pc.pop_front();
        e_nxt = q_nxt.pop_front();
        e_val = q_val.pop_front();
        e_we = q_we.pop_front();
        t = q_tag.pop_front();
        check(pc_o == e_pc, {t, "/R10"}, "pc_o", pc_o, e_pc);
        check(next_pc_o == e_nxt, t, "next_pc_o", next_pc_o, e_nxt);
        check(link_we_o == e_we, {t, "/R9"}, "link_we_o", 32'(link_we_o), 32'(e_we));
        check(link_dst_o == 5'd31, "R9", "link_dst_o", 32'(link_dst_o), 32'd31);
        if (e_we) check(link_val_o == e_val, "R7", "link_val_o", link_val_o, e_val);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pc_o == RV, "R1", "pc_o in reset", pc_o, RV);
    repeat (3) @(negedge clk);
    check(pc_o == RV, "R1", "pc_o held in reset", pc_o, RV);
    rst_n = 1'b1;
    instr_i = enc_i(6'd35, 16'd0);
    @(posedge clk);
    #1;
    check(pc_o == RV, "R1", "pc_o after first release edge", pc_o, RV);
    @(posedge clk);
    #1;
    check(pc_o == RV, "R1", "pc_o after second release edge", pc_o, RV);
    model_pc = RV;
  endtask

  initial begin
    model_pc = RV;
    do_reset();
    // Loop body at 80000
    step({6'd0, 5'd0, 5'd19, 5'd9, 5'd2, 6'd0}, 1'b0, 32'd0, "R2");
    step({6'd0, 5'd9, 5'd22, 5'd9, 5'd0, 6'd32}, 1'b0, 32'd0, "R2");
    step(enc_i(6'd35, 16'd0), 1'b0, 32'd0, "R2");
    step_x(enc_i(6'd5, 16'd2), 1'b0, 32'd0, 32'd80024, "R4");
    step_x(enc_ret(), 1'b0, 32'd80020, 32'd80020, "R8");
    step_x(enc_j(6'd2, 26'd20000), 1'b0, 32'd0, 32'd80000, "R6");
    step_x(enc_i(6'd4, 16'd5), 1'b1, 32'd0, 32'd80024, "R3");
    step_x(enc_i(6'd4, 16'd5), 1'b0, 32'd0, 32'd80028, "R3");
    step_x(enc_i(6'd5, 16'd7), 1'b1, 32'd0, 32'd80032, "R4");
    step_x(enc_i(6'd4, 16'hFFFD), 1'b1, 32'd0, 32'd80024, "R5");
    step_x(enc_i(6'd5, 16'h8000), 1'b0, 32'd0, 32'd80028 - 32'd131072, "R5");
    step(enc_j(6'd3, 26'h3FF_FFFF), 1'b0, 32'd0, "R7");
    step_x(enc_ret(), 1'b1, 32'h1FFF_FFFC, 32'h1FFF_FFFC, "R8");
    step_x(enc_j(6'd2, 26'h10), 1'b0, 32'd0, 32'h1000_0040, "R11");
    step_x(enc_j(6'd3, 26'd5), 1'b0, 32'd0, 32'h1000_0014, "R7");
    step({6'd0, 5'd31, 5'd0, 5'd31, 5'd0, 6'd9}, 1'b0, 32'h5555_0000, "R2");
    step(enc_i(6'd8, 16'hFFFF), 1'b1, 32'd0, "R2");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      logic [5:0] op;
      r = $urandom;
      case (r[2:0])
        3'd0: op = 6'd0;
        3'd1: op = 6'd2;
        3'd2: op = 6'd3;
        3'd3: op = 6'd4;
        3'd4: op = 6'd5;
        default: op = 6'(8 + r[7:3]);
      endcase
      if (op == 6'd0 && r[8]) step(enc_ret(), r[9], $urandom & 32'hFFFF_FFFC, "R8");
      else step({op, $urandom_range(0, 32'h03FF_FFFF)}, r[9],
                $urandom, "R10");
    end
    @(negedge clk);
    @(negedge clk);
    do_reset();
    step(enc_j(6'd3, 26'd77), 1'b0, 32'd0, "R7");
    step(enc_i(6'd4, 16'd1), 1'b1, 32'd0, "R3");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule